// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host walk through on-board packet RAM one data-port access at a time. The host loads a 16-bit current address and a 16-bit byte count with byte-wide register writes, then issues accesses on a valid/ready data port. Every accepted access touches RAM at the current address, moves the address forward by the access width and takes the same amount off the count. When the count runs out, a sticky completion flag is raised.

The address stays inside a receive ring: when it lands exactly on the ring stop address, it jumps back to the ring start address. The access width comes from a configuration bit (one or two bytes) or from a four-byte request flag. Multi-byte data is little-endian, with byte k on RAM lane k. Only the 32-byte identification area at the bottom of RAM and a parameterised packet window can be reached. Reads elsewhere return ones and writes elsewhere are dropped. The RAM port has four byte lanes, each with its own address, and returns read data in the same cycle.

Back-pressure: the engine accepts one access per handshake (`dp_valid && dp_ready`). `dp_ready` is low while a read response waits for `rsp_ready`, and in any cycle that carries a register write or a DMA command. The read response stays valid and stable until the host takes it.

Top module: `rdma_port_engine`

## Requirements
- R1: Register selects 0 and 1 write the low and high byte of the current address, and selects 2 and 3 write the low and high byte of the count. Each write changes only its own byte. Selects 0 and 1 read the current address back on `reg_rdata`, and select 4 reads the configuration byte.
- R2: The access width is 4 bytes when `dp_dword` is 1. Otherwise it is 2 bytes when configuration bit 0 (select 4) is 1, and 1 byte when that bit is 0. The address advances by the access width.
- R3: For 2- and 4-byte accesses, bit 0 of the RAM base address is forced to 0. Lane k uses address base+k and carries data byte k (little-endian).
- R4: If the advanced address equals the ring stop page × 256, it is replaced by the ring start page × 256.
- R5: If the count is at most the access width, it becomes 0 and the completion flag is set. Otherwise the count drops by the access width.
- R6: A data-port write accepted while the count is 0 is ignored: there is no RAM write enable, and the address, count and flag stay unchanged. A read at count 0 still performs the access, advances the address and sets the flag.
- R7: A DMA command issued while the count is 0 sets the completion flag on the next cycle. With a nonzero count, the command leaves the flag unchanged.
- R8: RAM is reachable only when the base address is below 32, or at or above WIN_LO and below WIN_HI. Outside these ranges, reads return 0xFF in every used lane and no write enable is raised, but the address and count still advance.
- R9: `done_clr` clears the completion flag. A set in the same cycle wins over the clear.
- R10: Read data appears on `rsp_data` one cycle after acceptance and is held stable until `rsp_ready`, with lanes above the access width reading 0. `dp_ready` is low while a response is pending, and during a register write or a DMA command.
- R11: After reset, the address, count, configuration and flag are 0, `rsp_valid` is 0 and `dp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register byte write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register readback for `reg_sel` |
| dma_cmd | input | 1 | Remote read/write command issued |
| done_clr | input | 1 | Clear the completion flag |
| done_flag | output | 1 | Sticky remote transfer complete flag |
| ring_start_pg | input | 8 | Ring first page |
| ring_stop_pg | input | 8 | Ring end page (exclusive) |
| dp_valid | input | 1 | Data-port access request |
| dp_ready | output | 1 | Data port can accept |
| dp_write | input | 1 | 1 = write, 0 = read |
| dp_dword | input | 1 | 1 = four-byte access |
| dp_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 32 | Read response data |
| ram_addr | output | 64 | Four lane byte addresses, lane 0 lowest |
| ram_we | output | 4 | Lane write enables |
| ram_wdata | output | 32 | Lane write data |
| ram_rdata | input | 32 | Lane read data, combinational |

## Verification
The bench sweeps every width setting over a transfer that crosses the ring stop. This catches a design that wraps on "greater or equal" or that wraps early, because the readback address would then miss 0x200 or skip bytes. A final partial access must clear the count and raise the flag together: an engine that decrements below zero or raises the flag one access late shows up in the flag checked after each access. Odd bases in wide modes, the identification area, out-of-window addresses and writes at zero count all check lane data and write enables at the RAM port. A design that forgets to force an even base, leaks writes or stalls the address would produce wrong readback bytes or a stray enable. Back-pressure, the zero-count command and the set-versus-clear race are each checked in the exact cycle they affect.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_CNT_LO  = 3'd2,
    SEL_CNT_HI  = 3'd3,
    SEL_CFG     = 3'd4
  } reg_sel_e;

  localparam int unsigned STEP_W = 3;

  function automatic logic [STEP_W-1:0] access_step(input logic dword, input logic wide);
    if (dword)     return 3'd4;
    else if (wide) return 3'd2;
    else           return 3'd1;
  endfunction
endpackage

// File: rtl/rdma_addr_ctr.sv
module rdma_addr_ctr #(
  parameter int unsigned AW = 16,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wdata,
  input  logic          adv,
  input  logic [SW-1:0] step,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] sum;
  logic [AW-1:0] nxt;

  assign sum = addr_q + AW'(step);

  always_comb begin
    nxt = addr_q;
    if (adv) nxt = (sum == ring_stop) ? ring_start : sum;
    if (wr_lo) nxt[7:0] = wdata;
    if (wr_hi) nxt[AW-1:8] = wdata[AW-9:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= nxt;
  end

  // R4: landing on the stop address reloads the start address
  p_wrap_to_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_lo && !wr_hi && (sum == ring_stop)) |=> (addr_q == $past(ring_start)))
    else $error("wrap to ring start missed");

  // R2: ordinary advance by the step
  p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_lo && !wr_hi && (sum != ring_stop)) |=> (addr_q == $past(addr_q) + AW'($past(step))))
    else $error("address did not advance by step");
endmodule

// File: rtl/rdma_count_ctr.sv
module rdma_count_ctr #(
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wdata,
  input  logic          adv,
  input  logic [SW-1:0] step,
  input  logic          dma_cmd,
  input  logic          done_clr,
  output logic [CW-1:0] cnt_q,
  output logic          cnt_zero,
  output logic          done_q
);
  logic          last;
  logic          done_set;
  logic [CW-1:0] nxt;

  assign cnt_zero = (cnt_q == '0);
  assign last     = (cnt_q <= CW'(step));
  assign done_set = (adv && last) || (dma_cmd && cnt_zero);

  always_comb begin
    nxt = cnt_q;
    if (adv) nxt = last ? '0 : cnt_q - CW'(step);
    if (wr_lo) nxt[7:0] = wdata;
    if (wr_hi) nxt[CW-1:8] = wdata[CW-9:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q <= nxt;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  // R5: final access empties the count and raises the flag
  p_last_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_lo && !wr_hi && (cnt_q <= CW'(step))) |=> (cnt_q == '0 && done_q))
    else $error("count did not finish");

  // R5: other accesses subtract the step
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_lo && !wr_hi && (cnt_q > CW'(step))) |=> (cnt_q == $past(cnt_q) - CW'($past(step))))
    else $error("count decrement wrong");

  // R7: command at zero count completes at once
  p_cmd_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_cmd && cnt_zero) |=> done_q)
    else $error("zero-count command did not complete");

  // R9: clear with no set drops the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !dma_cmd && !adv) |=> !done_q)
    else $error("flag clear failed");
endmodule

// File: rtl/rdma_lane_xlate.sv
module rdma_lane_xlate #(
  parameter int unsigned AW         = 16,
  parameter int unsigned LANES      = 4,
  parameter int unsigned SW         = 3,
  parameter int unsigned PROM_BYTES = 32,
  parameter int unsigned WIN_LO     = 16'h4000,
  parameter int unsigned WIN_HI     = 16'h8000
) (
  input  logic [AW-1:0]          addr,
  input  logic [SW-1:0]          step,
  input  logic                   wr_fire,
  input  logic [8*LANES-1:0]     wdata,
  input  logic [8*LANES-1:0]     ram_rdata,
  output logic [LANES*AW-1:0]    ram_addr,
  output logic [LANES-1:0]       ram_we,
  output logic [8*LANES-1:0]     ram_wdata,
  output logic [8*LANES-1:0]     rd_word
);
  logic [AW-1:0] base;
  logic          in_win;

  assign base   = (step > SW'(1)) ? {addr[AW-1:1], 1'b0} : addr;
  assign in_win = (base < AW'(PROM_BYTES)) ||
                  ((base >= AW'(WIN_LO)) && (base < AW'(WIN_HI)));
  assign ram_wdata = wdata;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_on;
    assign lane_on               = (SW'(k) < step);
    assign ram_addr[k*AW +: AW]  = base + AW'(k);
    assign ram_we[k]             = wr_fire && in_win && lane_on;
    assign rd_word[8*k +: 8]     = !lane_on ? 8'h00 :
                                   (in_win ? ram_rdata[8*k +: 8] : 8'hFF);
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned LANES      = 4,
  parameter int unsigned PROM_BYTES = 32,
  parameter int unsigned WIN_LO     = 16'h4000,
  parameter int unsigned WIN_HI     = 16'h8000,
  localparam int unsigned DW        = 8 * LANES,
  localparam int unsigned PW        = AW - 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_sel,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                dma_cmd,
  input  logic                done_clr,
  output logic                done_flag,
  input  logic [PW-1:0]       ring_start_pg,
  input  logic [PW-1:0]       ring_stop_pg,
  input  logic                dp_valid,
  output logic                dp_ready,
  input  logic                dp_write,
  input  logic                dp_dword,
  input  logic [DW-1:0]       dp_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_data,
  output logic [LANES*AW-1:0] ram_addr,
  output logic [LANES-1:0]    ram_we,
  output logic [DW-1:0]       ram_wdata,
  input  logic [DW-1:0]       ram_rdata
);
  logic              cfg_wide;
  logic [STEP_W-1:0] step;
  logic              fire, wr_ok, adv;
  logic [AW-1:0]     addr_q, cnt_q;
  logic              cnt_zero;
  logic [DW-1:0]     rd_word;
  logic              rsp_valid_q;
  logic [DW-1:0]     rsp_data_q;
  logic              w_alo, w_ahi, w_clo, w_chi, w_cfg;

  assign w_alo = reg_wr_en && (reg_sel == SEL_ADDR_LO);
  assign w_ahi = reg_wr_en && (reg_sel == SEL_ADDR_HI);
  assign w_clo = reg_wr_en && (reg_sel == SEL_CNT_LO);
  assign w_chi = reg_wr_en && (reg_sel == SEL_CNT_HI);
  assign w_cfg = reg_wr_en && (reg_sel == SEL_CFG);

  assign step     = access_step(dp_dword, cfg_wide);
  assign dp_ready = !rsp_valid_q && !reg_wr_en && !dma_cmd;
  assign fire     = dp_valid && dp_ready;
  assign wr_ok    = fire && dp_write && !cnt_zero;
  assign adv      = (fire && !dp_write) || wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_wide <= 1'b0;
    else if (w_cfg) cfg_wide <= reg_wdata[0];
  end

  rdma_addr_ctr #(.AW(AW), .SW(STEP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_lo(w_alo), .wr_hi(w_ahi), .wdata(reg_wdata),
    .adv(adv), .step(step),
    .ring_start({ring_start_pg, 8'h00}), .ring_stop({ring_stop_pg, 8'h00}),
    .addr_q(addr_q)
  );

  rdma_count_ctr #(.CW(AW), .SW(STEP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_lo(w_clo), .wr_hi(w_chi), .wdata(reg_wdata),
    .adv(adv), .step(step), .dma_cmd(dma_cmd), .done_clr(done_clr),
    .cnt_q(cnt_q), .cnt_zero(cnt_zero), .done_q(done_flag)
  );

  rdma_lane_xlate #(.AW(AW), .LANES(LANES), .SW(STEP_W), .PROM_BYTES(PROM_BYTES),
                    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_lane (
    .addr(addr_q), .step(step), .wr_fire(wr_ok), .wdata(dp_wdata),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (fire && !dp_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  always_comb begin
    case (reg_sel)
      SEL_ADDR_LO: reg_rdata = addr_q[7:0];
      SEL_ADDR_HI: reg_rdata = 8'(addr_q[AW-1:8]);
      SEL_CFG:     reg_rdata = {7'd0, cfg_wide};
      default:     reg_rdata = 8'h00;
    endcase
  end

  // R10: pending response holds until taken
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_data_q)))
    else $error("response dropped or changed");

  // R6: write at zero count leaves the address alone
  p_zero_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dp_write && cnt_zero) |=> $stable(addr_q))
    else $error("ignored write moved the address");

  // R6: lane enables only come from an accepted write with count left
  p_we_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_we) |-> (fire && dp_write && !cnt_zero))
    else $error("stray RAM write enable");
endmodule

// File: tb/rdma_port_engine_tb_top.sv
module rdma_port_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_sel = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        dma_cmd = 0, done_clr = 0, done_flag;
  logic [7:0]  ring_start_pg = 8'h02, ring_stop_pg = 8'h04;
  logic        dp_valid = 0, dp_ready, dp_write = 0, dp_dword = 0;
  logic [31:0] dp_wdata = 0;
  logic        rsp_valid, rsp_ready = 0;
  logic [31:0] rsp_data;
  logic [63:0] ram_addr;
  logic [3:0]  ram_we;
  logic [31:0] ram_wdata, ram_rdata;

  always #2.5 clk = ~clk;

  rdma_port_engine #(.WIN_LO(16'h0200), .WIN_HI(16'h0400)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_cmd(dma_cmd),
    .done_clr(done_clr), .done_flag(done_flag), .ring_start_pg(ring_start_pg),
    .ring_stop_pg(ring_stop_pg), .dp_valid(dp_valid), .dp_ready(dp_ready),
    .dp_write(dp_write), .dp_dword(dp_dword), .dp_wdata(dp_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  logic [7:0] bram [0:1023];
  for (genvar k = 0; k < 4; k++) begin : g_ram
    assign ram_rdata[8*k +: 8] = bram[ram_addr[16*k +: 10]];
  end

  int total = 0, bad = 0;

  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (ram_we[k]) begin
        bram[ram_addr[16*k +: 10]] <= ram_wdata[8*k +: 8];
        if (!(ram_addr[16*k +: 16] < 32 ||
              (ram_addr[16*k +: 16] >= 16'h200 && ram_addr[16*k +: 16] < 16'h400))) begin
          bad++;
          $display("FAIL R8 write outside window: act=%h exp=none", ram_addr[16*k +: 16]);
        end
      end
    end
  end

  logic [7:0]  exp_mem [0:1023];
  logic [15:0] m_addr = 0, m_cnt = 0;
  logic        m_cfg = 0, m_done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk); reg_wr_en = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_wr_en = 0;
    case (sel)
      3'd0: m_addr[7:0]  = val;
      3'd1: m_addr[15:8] = val;
      3'd2: m_cnt[7:0]   = val;
      3'd3: m_cnt[15:8]  = val;
      3'd4: m_cfg        = val[0];
      default: ;
    endcase
  endtask

  task automatic rd_addr(output logic [15:0] a);
    reg_sel = 3'd0; #1 a[7:0] = reg_rdata;
    reg_sel = 3'd1; #1 a[15:8] = reg_rdata;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] c);
    wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
    wreg(3'd2, c[7:0]); wreg(3'd3, c[15:8]);
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    m_done = 0;
  endtask

  task automatic acc(input bit wr, input bit dw, input logic [31:0] wd, input string tag);
    int s;
    logic [15:0] base, a;
    bit inw;
    logic [31:0] exp_rd, got;
    s = dw ? 4 : (m_cfg ? 2 : 1);
    base = (s > 1) ? {m_addr[15:1], 1'b0} : m_addr;
    inw = (base < 32) || (base >= 16'h200 && base < 16'h400);
    exp_rd = 0;
    for (int k = 0; k < 4; k++)
      if (k < s) exp_rd[8*k +: 8] = inw ? exp_mem[(base + k) & 16'h3FF] : 8'hFF;
    @(negedge clk); dp_valid = 1; dp_write = wr; dp_dword = dw; dp_wdata = wd;
    while (!dp_ready) @(negedge clk);
    @(negedge clk); dp_valid = 0;
    if (!wr) begin
      chk({tag, " R10 rsp_valid"}, {31'd0, rsp_valid}, 1);
      got = rsp_data;
      rsp_ready = 1; @(negedge clk); rsp_ready = 0;
      chk({tag, " R3 R8 R10 read data"}, got, exp_rd);
    end
    if (!(wr && m_cnt == 0)) begin
      if (wr && inw)
        for (int k = 0; k < 4; k++)
          if (k < s) exp_mem[(base + k) & 16'h3FF] = wd[8*k +: 8];
      m_addr = m_addr + 16'(s);
      if (m_addr == 16'h0400) m_addr = 16'h0200;
      if (m_cnt <= 16'(s)) begin m_cnt = 0; m_done = 1; end
      else m_cnt = m_cnt - 16'(s);
    end
    rd_addr(a);
    chk({tag, " R2 R4 address"}, {16'd0, a}, {16'd0, m_addr});
    chk({tag, " R5 done"}, {31'd0, done_flag}, {31'd0, m_done});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd_addr(a);
    chk("R11 addr", {16'd0, a}, 0);
    reg_sel = 3'd4; #1 chk("R11 cfg", {24'd0, reg_rdata}, 0);
    chk("R11 done", {31'd0, done_flag}, 0);
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R11 dp_ready", {31'd0, dp_ready}, 1);

    // R1 byte halves
    wreg(3'd0, 8'h34); wreg(3'd1, 8'h12);
    rd_addr(a); chk("R1 both halves", {16'd0, a}, 32'h1234);
    wreg(3'd0, 8'hCD);
    rd_addr(a); chk("R1 low only", {16'd0, a}, 32'h12CD);
    wreg(3'd4, 8'h01);
    reg_sel = 3'd4; #1 chk("R1 cfg readback", {24'd0, reg_rdata}, 1);

    // R2 R4 R5 sweep: every width, transfer crossing the ring stop
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int dw = 0; dw < 2; dw++) begin
        int s, n;
        s = dw ? 4 : (cfg ? 2 : 1);
        n = (41 + s - 1) / s;
        wreg(3'd4, 8'(cfg));
        clear_done();
        setup(16'h03E0, 16'd41);
        for (int i = 0; i < n; i++)
          acc(1, dw[0], 32'hA5C31E00 ^ (32'(i) * 32'h01030507) ^ 32'(cfg << 4) ^ 32'(dw << 5),
              "sweep write");
        acc(1, dw[0], 32'hDEADBEEF, "R6 zero-count write");
        clear_done();
        setup(16'h03E0, 16'd41);
        for (int i = 0; i < n; i++) acc(0, dw[0], 0, "sweep read");
      end
    end

    // R3 odd base in 2-byte mode, little-endian lanes
    wreg(3'd4, 8'h01); clear_done();
    setup(16'h0205, 16'd4);
    acc(1, 0, 32'h0000BEEF, "R3 odd wide write");
    wreg(3'd4, 8'h00);
    setup(16'h0204, 16'd2);
    acc(0, 0, 0, "R3 low lane");
    chk("R3 byte0", {24'd0, exp_mem[16'h204]}, 32'hEF);
    acc(0, 0, 0, "R3 high lane");
    chk("R3 byte1", {24'd0, exp_mem[16'h205]}, 32'hBE);
    setup(16'h020B, 16'd8);
    acc(1, 1, 32'h44332211, "R3 odd dword write");
    setup(16'h020A, 16'd4);
    acc(0, 1, 0, "R3 dword read");

    // R8 identification area and out-of-window
    clear_done();
    setup(16'h0010, 16'd4);
    acc(1, 1, 32'h57575757, "R8 prom write");
    setup(16'h0010, 16'd4);
    acc(0, 1, 0, "R8 prom read");
    setup(16'h0100, 16'd8);
    acc(1, 1, 32'h12345678, "R8 outside write");
    acc(0, 1, 0, "R8 outside dword read");
    wreg(3'd4, 8'h00);
    acc(0, 0, 0, "R8 outside byte read");

    // R6 read at zero count still advances and completes
    clear_done();
    setup(16'h0204, 16'd0);
    acc(0, 0, 0, "R6 zero-count read");

    // R7 command at zero and nonzero count
    clear_done();
    setup(16'h0200, 16'd0);
    @(negedge clk); dma_cmd = 1; #1 chk("R10 ready low on cmd", {31'd0, dp_ready}, 0);
    @(negedge clk); dma_cmd = 0;
    chk("R7 zero-count command", {31'd0, done_flag}, 1);
    clear_done();
    setup(16'h0200, 16'd5);
    @(negedge clk); dma_cmd = 1; @(negedge clk); dma_cmd = 0;
    chk("R7 nonzero command", {31'd0, done_flag}, 0);

    // R9 set beats clear
    setup(16'h0200, 16'd0);
    @(negedge clk); dma_cmd = 1; done_clr = 1;
    @(negedge clk); dma_cmd = 0; done_clr = 0;
    chk("R9 set wins", {31'd0, done_flag}, 1);
    clear_done();
    chk("R9 clear", {31'd0, done_flag}, 0);

    // R10 back-pressure and ready during register write
    setup(16'h0204, 16'd4);
    @(negedge clk); reg_wr_en = 1; reg_sel = 3'd5; #1
    chk("R10 ready low on reg write", {31'd0, dp_ready}, 0);
    @(negedge clk); reg_wr_en = 0; dp_valid = 1; dp_write = 0; dp_dword = 0;
    @(negedge clk); dp_valid = 0;
    hold = rsp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held valid", {31'd0, rsp_valid}, 1);
      chk("R10 held data", rsp_data, hold);
      chk("R10 ready low while pending", {31'd0, dp_ready}, 0);
    end
    chk("R10 data value", hold, {24'd0, exp_mem[16'h204]});
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    chk("R10 released", {31'd0, rsp_valid}, 0);
    chk("R10 ready back", {31'd0, dp_ready}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule